// File: doc/BRIEF.md
# Auto-Incrementing Register Access Pointer

This block is the byte-level access engine that sits behind a two-wire serial slave. A bus front end turns the wire activity into single-cycle events: a transaction start with its direction, a received data byte, a request for a byte to send, and a stop. The engine holds one stored command pointer. It uses that pointer to issue write strobes and read requests to a register bank that spans addresses 0x00 to 0x26.

In a write transaction the first byte loads the pointer, and every later byte is written to the register the pointer selects. A read transaction carries no address. It returns bytes starting at the stored pointer. After each byte read or written, the pointer moves up by one until it reaches the top address. From then on it stays at the top address and never wraps. The pointer keeps its value across stops and repeated starts. A read that follows a write burst therefore continues after the last written register, unless a new command byte reloads the pointer.

Top module: `cmd_ptr_engine`

## Requirements
- R1: Reset clears the pointer to 0x00 and leaves `bank_we`, `bank_re` and `rd_valid` low. The first read after reset addresses 0x00.
- R2: The first `wr_valid` byte after a write-direction start loads the pointer with that byte. A value above 0x26 loads 0x26. This byte produces no write strobe.
- R3: Every later `wr_valid` byte of that write transaction makes `bank_we` high for exactly one cycle, in the cycle after the byte. In that cycle `bank_waddr` equals the pointer and `bank_wdata` equals the byte.
- R4: A `rd_req` in a read-direction transaction drives `bank_re` high with `bank_raddr` equal to the pointer in the same cycle. `rd_valid` is high with `rd_data` in the following cycle.
- R5: After each data byte read or written, a pointer below 0x26 increases by one.
- R6: A pointer at 0x26 stays at 0x26 after any number of further reads or writes and never returns to 0x00.
- R7: Addresses 0x0C–0x0F and 0x1C–0x1F are unimplemented. A data byte aimed at one of them produces no write strobe, but the pointer still advances.
- R8: A read from an unimplemented address returns 0x00, whatever the bank drives.
- R9: The pointer keeps its value across stops and repeated starts. A read after a write burst starts one past the last written address, or at 0x26 once saturated.
- R10: Out-of-phase events are ignored and leave the pointer unchanged. These are a written byte while idle or in a read transaction, and `rd_req` while idle or in a write transaction. They produce no strobe and no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Start or repeated start, one-cycle pulse |
| txn_read | input | 1 | Direction qualifier with `txn_start`: 1 = read |
| txn_stop | input | 1 | Stop condition, one-cycle pulse |
| wr_valid | input | 1 | Received byte from master is present |
| wr_byte | input | 8 | Received byte |
| rd_req | input | 1 | Front end needs the next byte to send |
| bank_re | output | 1 | Read request to register bank |
| bank_raddr | output | 8 | Read address (current pointer) |
| bank_rdata | input | 8 | Bank read data, combinational from `bank_raddr` |
| rd_valid | output | 1 | `rd_data` holds the requested byte |
| rd_data | output | 8 | Byte to send to the master |
| bank_we | output | 1 | Register write strobe |
| bank_waddr | output | 8 | Write address |
| bank_wdata | output | 8 | Write data |

## Verification
The bench sweeps every command value from 0x00 to 0x29 with write and read bursts. This covers the saturation corner from both sides and the clamping of oversized command bytes. A design that wrapped would show 0x00 after 0x26, and one that failed to clamp would address past the bank. The sweep also crosses each unimplemented hole. A missing write gate would corrupt the bench's bank there, and a missing read mask would leak the bank's filler value 0xEE. Separate cases cover persistence across stop and repeated start, and out-of-phase bytes and requests. A design that reset or moved the pointer on these would read from the wrong address afterwards.

// File: rtl/cmd_ptr_pkg.sv
package cmd_ptr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CMD   = 2'd1,
        PH_WDATA = 2'd2,
        PH_READ  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [BYTE_W-1:0]   ptr;
        logic                we;
        logic [BYTE_W-1:0]   waddr;
        logic [BYTE_W-1:0]   wdata;
        logic                rvalid;
        logic [BYTE_W-1:0]   rdata;
    } eng_state_t;

endpackage

// File: rtl/cmd_ptr_satinc.sv
module cmd_ptr_satinc #(
    parameter int W        = 8,
    parameter int TOP_ADDR = 38
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] raw_load,
    output logic [W-1:0] inc,
    output logic [W-1:0] clamped
);
    localparam logic [W-1:0] TOP = W'(TOP_ADDR);

    always_comb begin
        inc     = (cur < TOP) ? cur + W'(1) : TOP;
        clamped = (raw_load > TOP) ? TOP : raw_load;
    end
endmodule

// File: rtl/cmd_ptr_impl.sv
module cmd_ptr_impl #(
    parameter int               W         = 8,
    parameter int               NUM_REGS  = 39,
    parameter logic [NUM_REGS-1:0] IMPL_MASK = '1
) (
    input  logic [W-1:0] addr,
    output logic         hit
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx = addr[IDX_W-1:0];
        hit = (addr < W'(NUM_REGS)) ? IMPL_MASK[idx] : 1'b0;
    end
endmodule

// File: rtl/cmd_ptr_engine.sv
module cmd_ptr_engine
    import cmd_ptr_pkg::*;
#(
    parameter int TOP_ADDR = 38,
    parameter logic [TOP_ADDR:0] IMPL_MASK = 39'h7F_0FFF_0FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              txn_read,
    input  logic              txn_stop,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_req,
    output logic              bank_re,
    output logic [BYTE_W-1:0] bank_raddr,
    input  logic [BYTE_W-1:0] bank_rdata,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              bank_we,
    output logic [BYTE_W-1:0] bank_waddr,
    output logic [BYTE_W-1:0] bank_wdata
);
    localparam int NUM_REGS = TOP_ADDR + 1;

    eng_state_t s_q, s_d;
    logic [BYTE_W-1:0] ptr_inc, ptr_load;
    logic              ptr_hit;
    logic              rd_take;

    cmd_ptr_satinc #(.W(BYTE_W), .TOP_ADDR(TOP_ADDR)) u_inc (
        .cur      (s_q.ptr),
        .raw_load (wr_byte),
        .inc      (ptr_inc),
        .clamped  (ptr_load)
    );

    cmd_ptr_impl #(.W(BYTE_W), .NUM_REGS(NUM_REGS), .IMPL_MASK(IMPL_MASK)) u_impl (
        .addr (s_q.ptr),
        .hit  (ptr_hit)
    );

    // Read is accepted only when no higher-priority event shares the cycle.
    assign rd_take = rd_req && (s_q.phase == PH_READ)
                     && !txn_start && !txn_stop && !wr_valid;

    always_comb begin
        s_d        = s_q;
        s_d.we     = 1'b0;
        s_d.rvalid = 1'b0;
        if (txn_start) begin
            s_d.phase = txn_read ? PH_READ : PH_CMD;
        end else if (txn_stop) begin
            s_d.phase = PH_IDLE;
        end else if (wr_valid) begin
            case (s_q.phase)
                PH_CMD: begin
                    s_d.ptr   = ptr_load;
                    s_d.phase = PH_WDATA;
                end
                PH_WDATA: begin
                    s_d.we    = ptr_hit;
                    s_d.waddr = s_q.ptr;
                    s_d.wdata = wr_byte;
                    s_d.ptr   = ptr_inc;
                end
                default: ;
            endcase
        end else if (rd_take) begin
            s_d.rvalid = 1'b1;
            s_d.rdata  = ptr_hit ? bank_rdata : '0;
            s_d.ptr    = ptr_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase  <= PH_IDLE;
            s_q.ptr    <= '0;
            s_q.we     <= 1'b0;
            s_q.waddr  <= '0;
            s_q.wdata  <= '0;
            s_q.rvalid <= 1'b0;
            s_q.rdata  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bank_re    = rd_take;
    assign bank_raddr = s_q.ptr;
    assign rd_valid   = s_q.rvalid;
    assign rd_data    = s_q.rdata;
    assign bank_we    = s_q.we;
    assign bank_waddr = s_q.waddr;
    assign bank_wdata = s_q.wdata;
endmodule

// File: rtl/cmd_ptr_engine_chk.sv
module cmd_ptr_engine_chk #(
    parameter int TOP_ADDR = 38,
    parameter logic [TOP_ADDR:0] IMPL_MASK = '1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       txn_start,
    input logic       txn_stop,
    input logic       wr_valid,
    input logic       rd_req,
    input logic       bank_re,
    input logic [7:0] bank_raddr,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       bank_we,
    input logic [7:0] bank_waddr
);
    localparam logic [7:0] TOP = 8'(TOP_ADDR);

    function automatic logic impl_at(input logic [7:0] a);
        return (a <= TOP) ? IMPL_MASK[a[5:0]] : 1'b0;
    endfunction

    p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({txn_start, txn_stop, wr_valid, rd_req}));

    p_ptr_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bank_raddr <= TOP);

    p_read_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bank_re && bank_raddr < TOP |=> bank_raddr == $past(bank_raddr) + 8'd1);

    p_read_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bank_re && bank_raddr == TOP |=> bank_raddr == TOP);

    p_read_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_re |=> rd_valid);

    p_no_spurious_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_re |=> !rd_valid);

    p_hole_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bank_re && !impl_at(bank_raddr) |=> rd_data == 8'h00);

    p_hole_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> impl_at(bank_waddr));

    p_write_in_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> bank_waddr <= TOP);
endmodule

bind cmd_ptr_engine cmd_ptr_engine_chk #(.TOP_ADDR(TOP_ADDR), .IMPL_MASK(IMPL_MASK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_start  (txn_start),
    .txn_stop   (txn_stop),
    .wr_valid   (wr_valid),
    .rd_req     (rd_req),
    .bank_re    (bank_re),
    .bank_raddr (bank_raddr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .bank_we    (bank_we),
    .bank_waddr (bank_waddr)
);

// File: tb/tb_cmd_ptr_engine.sv
module tb_cmd_ptr_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0, txn_read = 1'b0, txn_stop = 1'b0;
    logic       wr_valid = 1'b0, rd_req = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       bank_re, rd_valid, bank_we;
    logic [7:0] bank_raddr, bank_rdata, rd_data, bank_waddr, bank_wdata;

    logic [7:0] bank_mem [64];
    logic [7:0] exp_mem  [64];
    int         vectors = 0, miscompares = 0;
    int         ptr_m = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    cmd_ptr_engine dut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_read(txn_read),
        .txn_stop(txn_stop), .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req),
        .bank_re(bank_re), .bank_raddr(bank_raddr), .bank_rdata(bank_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .bank_we(bank_we),
        .bank_waddr(bank_waddr), .bank_wdata(bank_wdata)
    );

    function automatic bit impl(input int a);
        return (a <= 38) && !(a >= 12 && a <= 15) && !(a >= 28 && a <= 31);
    endfunction

    assign bank_rdata = impl(int'(bank_raddr)) ? bank_mem[bank_raddr[5:0]] : 8'hEE;

    always @(posedge clk) if (bank_we) bank_mem[bank_waddr[5:0]] <= bank_wdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int step(input int p);
        return (p < 38) ? p + 1 : 38;
    endfunction

    task automatic start_txn(input bit rd);
        txn_start = 1'b1; txn_read = rd;
        @(negedge clk);
        txn_start = 1'b0; txn_read = 1'b0;
    endtask

    task automatic stop_txn();
        txn_stop = 1'b1;
        @(negedge clk);
        txn_stop = 1'b0;
    endtask

    task automatic send_cmd(input int c);
        wr_valid = 1'b1; wr_byte = 8'(c);
        @(negedge clk);
        wr_valid = 1'b0;
        check(bank_we == 1'b0, "R2 cmd byte no strobe", int'(bank_we), 0);
        ptr_m = (c > 38) ? 38 : c;
    endtask

    task automatic send_data(input logic [7:0] b);
        bit we_exp;
        we_exp = impl(ptr_m);
        wr_valid = 1'b1; wr_byte = b;
        @(negedge clk);
        wr_valid = 1'b0;
        check(bank_we == we_exp, we_exp ? "R3 strobe" : "R7 hole strobe", int'(bank_we), int'(we_exp));
        if (we_exp) begin
            check(bank_waddr == 8'(ptr_m), "R5 write address", int'(bank_waddr), ptr_m);
            check(bank_wdata == b, "R3 write data", int'(bank_wdata), int'(b));
            exp_mem[ptr_m] = b;
        end
        ptr_m = step(ptr_m);
    endtask

    task automatic read_byte();
        int exp_d;
        exp_d = impl(ptr_m) ? int'(exp_mem[ptr_m]) : 0;
        rd_req = 1'b1;
        #1;
        check(bank_re == 1'b1, "R4 read request", int'(bank_re), 1);
        check(bank_raddr == 8'(ptr_m), ptr_m == 38 ? "R6 read address" : "R5 read address",
              int'(bank_raddr), ptr_m);
        @(negedge clk);
        rd_req = 1'b0;
        check(rd_valid == 1'b1, "R4 read valid", int'(rd_valid), 1);
        check(rd_data == 8'(exp_d), impl(ptr_m) ? "R4 read data" : "R8 hole reads zero",
              int'(rd_data), exp_d);
        ptr_m = step(ptr_m);
    endtask

    initial begin
        for (int a = 0; a < 64; a++) begin
            bank_mem[a] = 8'(a * 3 + 1);
            exp_mem[a]  = 8'(a * 3 + 1);
        end
        repeat (3) @(negedge clk);
        check(bank_we == 0 && rd_valid == 0, "R1 reset outputs", int'({bank_we, rd_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        start_txn(1'b1);
        read_byte();                       // R1: first read from 0x00 (ptr_m = 0)
        stop_txn();

        // R2 R3 R5 R6 R7 R8: sweep command values across the whole range
        for (int s = 0; s <= 41; s++) begin
            start_txn(1'b0);
            send_cmd(s);
            for (int k = 0; k < 3; k++) send_data(8'(s * 7 + k + 1));
            stop_txn();
            start_txn(1'b1);               // R9: continues after burst
            for (int k = 0; k < 2; k++) read_byte();
            stop_txn();
            start_txn(1'b1);               // R9: persists across stop
            read_byte();
            stop_txn();
        end

        // R6: long burst sticking at top
        start_txn(1'b0);
        send_cmd(36);
        for (int k = 0; k < 6; k++) send_data(8'(8'hA0 + k));
        stop_txn();
        start_txn(1'b1);
        for (int k = 0; k < 4; k++) read_byte();
        stop_txn();

        // R9: repeated start from write phase into read
        start_txn(1'b0);
        send_cmd(5);
        start_txn(1'b1);
        read_byte();
        stop_txn();

        // R10: byte while idle
        wr_valid = 1'b1; wr_byte = 8'h33;
        @(negedge clk);
        wr_valid = 1'b0;
        check(bank_we == 0, "R10 idle byte no strobe", int'(bank_we), 0);
        // R10: rd_req while idle
        rd_req = 1'b1; #1;
        check(bank_re == 0, "R10 idle rd_req ignored", int'(bank_re), 0);
        @(negedge clk); rd_req = 1'b0;
        check(rd_valid == 0, "R10 idle no valid", int'(rd_valid), 0);
        // R10: rd_req during write data phase
        start_txn(1'b0);
        send_cmd(20);
        rd_req = 1'b1; #1;
        check(bank_re == 0, "R10 write-phase rd_req ignored", int'(bank_re), 0);
        @(negedge clk); rd_req = 1'b0;
        check(rd_valid == 0, "R10 write-phase no valid", int'(rd_valid), 0);
        send_data(8'h5C);                  // must land at 20
        stop_txn();
        // R10: byte during read phase
        start_txn(1'b1);
        wr_valid = 1'b1; wr_byte = 8'h01;
        @(negedge clk);
        wr_valid = 1'b0;
        check(bank_we == 0, "R10 read-phase byte no strobe", int'(bank_we), 0);
        read_byte();                       // pointer must still be 21
        stop_txn();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule